// File: doc/BRIEF.md
# Duplicate relation lookup table

This block holds a small, fully associative record of which cache blocks carry identical content. Each entry pairs the full tag-index of a block that missed with the full tag-index of a resident block found to hold the same data. On a cache miss the fetch path presents the missed tag-index. One cycle later the table reports a hit and the duplicate's tag-index, so the refill can be served from inside the cache.

New relations arrive from the duplicate detection flow as insert requests. Each request carries side-band filter inputs: the starting addresses and the conditional branch direction bits of both blocks. The table stores a relation only if the high address bits and the branch patterns agree. A request that fails the filter is answered with a one-cycle reject pulse and leaves the table unchanged. A single flush input clears every relation in one cycle, for use when code is rewritten or pages are remapped.

Top module: `dup_rel_table`

## Requirements
- R1: After reset no entry is valid, and `lk_hit`, `lk_dup_ti` and `ins_reject` are all zero.
- R2: A lookup presented with `lk_valid` in cycle N produces its result after the next clock edge. `lk_hit` is 1 and `lk_dup_ti` is the stored duplicate tag-index when a valid entry holds the looked-up tag-index. Otherwise both outputs are 0, and both are also 0 when `lk_valid` is low.
- R3: `flush` invalidates every entry at the clock edge and returns the replacement pointer to 0. An insert in the same cycle as a flush is dropped and does not raise a reject.
- R4: An insert is rejected when the top 9 bits of `ins_miss_addr` and `ins_dup_addr` (bits ADDR_W-1 down to ADDR_W-9) differ.
- R5: An insert is rejected when `ins_miss_br` and `ins_dup_br` differ in any bit.
- R6: An accepted insert whose missed tag-index is already stored overwrites that entry's duplicate tag-index and does not allocate another entry.
- R7: An accepted insert of a new tag-index goes to the lowest-numbered free entry. When every entry is valid, it replaces the entry at a round-robin pointer that starts at 0 and advances by one, wrapping, after each replacement.
- R8: A lookup and an insert in the same cycle return the table contents as they were before that insert.
- R9: A rejected insert raises `ins_reject` for exactly one cycle, in the cycle after the request, and changes no entry.
- R10: A match needs all TI_W bits of the tag-index to be equal. A tag-index that differs from a stored one in any single bit misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear all relations |
| lk_valid | input | 1 | Lookup request |
| lk_ti | input | TI_W | Tag-index of the missed block |
| lk_hit | output | 1 | Registered lookup hit |
| lk_dup_ti | output | TI_W | Registered duplicate tag-index |
| ins_valid | input | 1 | Insert request |
| ins_miss_ti | input | TI_W | Tag-index of the missed block |
| ins_dup_ti | input | TI_W | Tag-index of its resident duplicate |
| ins_miss_addr | input | ADDR_W | Start address of the missed block |
| ins_dup_addr | input | ADDR_W | Start address of the duplicate block |
| ins_miss_br | input | BR_W | Branch direction bits of the missed block |
| ins_dup_br | input | BR_W | Branch direction bits of the duplicate block |
| ins_reject | output | 1 | One-cycle pulse when an insert fails the filter |

## Verification
Random traffic draws tag-indices from a pool slightly larger than the table, so lookups hit, miss and catch entries just after they have been replaced. This separates correct allocation and round-robin victim choice from mistakes in either. Filter inputs are kept mostly equal and are made to differ sometimes, in the address high bits or in the branch bits, so each filter condition is exercised on its own. Directed cases cover a tag-index differing only in its top bit, a lookup in the same cycle as an insert to the same key, an update in place, and a flush that coincides with an insert.

// File: rtl/dr_pkg.sv
package dr_pkg;
    typedef struct packed {
        logic        vld;
        logic [29:0] key;
        logic [29:0] dup;
    } dr_entry_t;
endpackage

// File: rtl/dr_filter.sv
module dr_filter #(
    parameter int ADDR_W  = 32,
    parameter int HI_BITS = 9,
    parameter int BR_W    = 8
) (
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [ADDR_W-1:0] dup_addr,
    input  logic [BR_W-1:0]   miss_br,
    input  logic [BR_W-1:0]   dup_br,
    output logic              accept
);
    localparam int LO = ADDR_W - HI_BITS;
    logic hi_eq;
    logic br_eq;
    always_comb begin
        hi_eq  = (miss_addr[ADDR_W-1:LO] == dup_addr[ADDR_W-1:LO]);
        br_eq  = (miss_br == dup_br);
        accept = hi_eq && br_eq;
    end
endmodule

// File: rtl/dr_match.sv
module dr_match #(
    parameter int ENTRIES = 16,
    parameter int TI_W    = 30
) (
    input  logic [ENTRIES-1:0]           vld,
    input  logic [ENTRIES-1:0][TI_W-1:0] keys,
    input  logic [TI_W-1:0]              probe,
    output logic [ENTRIES-1:0]           hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hits[g] = vld[g] && (keys[g] == probe);
    end
endmodule

// File: rtl/dr_pick.sv
module dr_pick #(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] free_vec,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   slot,
    output logic               use_rr
);
    always_comb begin
        slot   = rr_ptr;
        use_rr = 1'b1;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                slot   = IDX_W'(i);
                use_rr = 1'b0;
            end
        end
    end
endmodule

// File: rtl/dup_rel_table.sv
module dup_rel_table #(
    parameter int ENTRIES = 16,
    parameter int TI_W    = 30,
    parameter int ADDR_W  = 32,
    parameter int HI_BITS = 9,
    parameter int BR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [TI_W-1:0]   lk_ti,
    output logic              lk_hit,
    output logic [TI_W-1:0]   lk_dup_ti,
    input  logic              ins_valid,
    input  logic [TI_W-1:0]   ins_miss_ti,
    input  logic [TI_W-1:0]   ins_dup_ti,
    input  logic [ADDR_W-1:0] ins_miss_addr,
    input  logic [ADDR_W-1:0] ins_dup_addr,
    input  logic [BR_W-1:0]   ins_miss_br,
    input  logic [BR_W-1:0]   ins_dup_br,
    output logic              ins_reject
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [ENTRIES-1:0]           vld;
        logic [ENTRIES-1:0][TI_W-1:0] key;
        logic [ENTRIES-1:0][TI_W-1:0] dup;
        logic [IDX_W-1:0]             rr;
        logic                         hit;
        logic [TI_W-1:0]              res;
        logic                         rej;
    } state_t;

    state_t st_d, st_q;

    logic               acc;
    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] ins_hits;
    logic [IDX_W-1:0]   free_slot;
    logic               use_rr;

    dr_filter #(.ADDR_W(ADDR_W), .HI_BITS(HI_BITS), .BR_W(BR_W)) u_filter (
        .miss_addr(ins_miss_addr), .dup_addr(ins_dup_addr),
        .miss_br(ins_miss_br), .dup_br(ins_dup_br), .accept(acc));

    dr_match #(.ENTRIES(ENTRIES), .TI_W(TI_W)) u_lk_match (
        .vld(st_q.vld), .keys(st_q.key), .probe(lk_ti), .hits(lk_hits));

    dr_match #(.ENTRIES(ENTRIES), .TI_W(TI_W)) u_ins_match (
        .vld(st_q.vld), .keys(st_q.key), .probe(ins_miss_ti), .hits(ins_hits));

    dr_pick #(.ENTRIES(ENTRIES)) u_pick (
        .free_vec(~st_q.vld), .rr_ptr(st_q.rr), .slot(free_slot), .use_rr(use_rr));

    always_comb begin
        st_d     = st_q;
        st_d.hit = 1'b0;
        st_d.res = '0;
        st_d.rej = 1'b0;
        // lookup sees the contents held before this cycle's write
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_valid && lk_hits[i]) begin
                st_d.hit = 1'b1;
                st_d.res = st_q.dup[i];
            end
        end
        if (flush) begin
            st_d.vld = '0;
            st_d.rr  = '0;
        end else if (ins_valid && !acc) begin
            st_d.rej = 1'b1;
        end else if (ins_valid) begin
            if (|ins_hits) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (ins_hits[i]) st_d.dup[i] = ins_dup_ti;
                end
            end else begin
                st_d.vld[free_slot] = 1'b1;
                st_d.key[free_slot] = ins_miss_ti;
                st_d.dup[free_slot] = ins_dup_ti;
                if (use_rr) st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
        end else begin
            st_q     <= st_d;
        end
    end

    assign lk_hit     = st_q.hit;
    assign lk_dup_ti  = st_q.res;
    assign ins_reject = st_q.rej;

    p_idle_no_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!lk_hit && lk_dup_ti == '0));

    p_flush_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.vld == '0 && !ins_reject));

    p_addr_filter_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !flush &&
         ins_miss_addr[ADDR_W-1:ADDR_W-HI_BITS] != ins_dup_addr[ADDR_W-1:ADDR_W-HI_BITS])
        |=> ins_reject);

    p_br_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !flush && ins_miss_br != ins_dup_br) |=> ins_reject);

    p_unique_key_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ins_hits));

    p_reject_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !flush && !acc) |=>
        (st_q.vld == $past(st_q.vld) && st_q.key == $past(st_q.key) &&
         st_q.dup == $past(st_q.dup)));
endmodule

// File: tb/tb_dup_rel_table.sv
module tb_dup_rel_table;
    localparam int N  = 16;
    localparam int TW = 30;
    localparam int AW = 32;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          lk_valid = 1'b0;
    logic [TW-1:0] lk_ti = '0;
    logic          lk_hit;
    logic [TW-1:0] lk_dup_ti;
    logic          ins_valid = 1'b0;
    logic [TW-1:0] ins_miss_ti = '0, ins_dup_ti = '0;
    logic [AW-1:0] ins_miss_addr = '0, ins_dup_addr = '0;
    logic [BW-1:0] ins_miss_br = '0, ins_dup_br = '0;
    logic          ins_reject;

    always #5 clk = ~clk;

    dup_rel_table dut (.*);

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    logic          m_v[N];
    logic [TW-1:0] m_k[N];
    logic [TW-1:0] m_d[N];
    int            m_rr = 0;

    logic          e_hit = 0, e_rej = 0;
    logic [TW-1:0] e_dup = '0;
    string         e_tag = "R1";

    function automatic int m_find(input logic [TW-1:0] k);
        for (int i = 0; i < N; i++) if (m_v[i] && m_k[i] == k) return i;
        return -1;
    endfunction

    function automatic int m_free();
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic fl, input logic lv, input logic [TW-1:0] lt,
                        input logic iv, input logic [TW-1:0] mt, input logic [TW-1:0] dt,
                        input logic [AW-1:0] ma, input logic [AW-1:0] da,
                        input logic [BW-1:0] mb, input logic [BW-1:0] db,
                        input string tag);
        int f;
        bit acc;
        @(negedge clk);
        chk({e_tag, " hit"}, 64'(lk_hit), 64'(e_hit));
        chk({e_tag, " dup"}, 64'(lk_dup_ti), 64'(e_dup));
        chk({e_tag, " reject"}, 64'(ins_reject), 64'(e_rej));
        flush = fl; lk_valid = lv; lk_ti = lt; ins_valid = iv;
        ins_miss_ti = mt; ins_dup_ti = dt; ins_miss_addr = ma; ins_dup_addr = da;
        ins_miss_br = mb; ins_dup_br = db;
        e_tag = tag;
        f = m_find(lt);
        e_hit = lv && (f >= 0);
        e_dup = e_hit ? m_d[f] : '0;
        acc = (ma[AW-1:AW-9] == da[AW-1:AW-9]) && (mb == db);
        e_rej = iv && !fl && !acc;
        if (fl) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_rr = 0;
        end else if (iv && acc) begin
            f = m_find(mt);
            if (f >= 0) m_d[f] = dt;
            else begin
                f = m_free();
                if (f < 0) begin
                    f = m_rr;
                    m_rr = (m_rr + 1) % N;
                end
                m_v[f] = 1; m_k[f] = mt; m_d[f] = dt;
            end
        end
    endtask

    function automatic logic [TW-1:0] key(input int k);
        return {6'h2B, 24'(k)};
    endfunction

    localparam logic [AW-1:0] A0 = 32'h1230_0040;

    initial begin
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_k[i] = '0; m_d[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(0, 1, key(1), 0, 0, 0, 0, 0, 0, 0, "R1");
        // R7 fill with ascending keys
        for (int i = 0; i < N; i++)
            step(0, 0, 0, 1, key(i), key(100 + i), A0, A0 + 32'h40, 8'h5, 8'h5, "R7");
        for (int i = 0; i < N; i++)
            step(0, 1, key(i), 0, 0, 0, 0, 0, 0, 0, "R2");
        // R7: replacement of entry 0 then 1
        step(0, 0, 0, 1, key(50), key(150), A0, A0, 0, 0, "R7");
        step(0, 1, key(0), 0, 0, 0, 0, 0, 0, 0, "R7");
        step(0, 1, key(50), 1, key(51), key(151), A0, A0, 0, 0, "R7");
        step(0, 1, key(1), 0, 0, 0, 0, 0, 0, 0, "R7");
        // R10: single top bit differs
        step(0, 1, key(5) ^ (30'h1 << 29), 0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 1, key(5) ^ 30'h1, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R8: same-cycle lookup and update
        step(0, 1, key(6), 1, key(6), key(777), A0, A0, 1, 1, "R8");
        step(0, 1, key(6), 0, 0, 0, 0, 0, 0, 0, "R6");
        // R4: top address bit differs; lookup confirms no change (R9)
        step(0, 0, 0, 1, key(7), key(999), A0, A0 ^ 32'h8000_0000, 3, 3, "R4");
        step(0, 1, key(7), 0, 0, 0, 0, 0, 0, 0, "R9");
        step(0, 0, 0, 1, key(7), key(999), A0, A0 ^ 32'h0080_0000, 3, 3, "R4");
        step(0, 0, 0, 1, key(7), key(999), A0, A0 ^ 32'h0040_0000, 3, 3, "R4");
        // R5: one branch bit differs
        step(0, 0, 0, 1, key(8), key(999), A0, A0, 8'h80, 8'h00, "R5");
        step(0, 1, key(8), 0, 0, 0, 0, 0, 0, 0, "R9");
        // R3: flush with coincident insert
        step(1, 1, key(9), 1, key(9), key(5), A0, A0 ^ 32'h8000_0000, 0, 0, "R3");
        step(0, 1, key(9), 0, 0, 0, 0, 0, 0, 0, "R3");
        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [AW-1:0] ma, da;
            logic [BW-1:0] mb, db;
            int r;
            ma = $urandom;
            da = ($urandom_range(0, 9) < 8) ? {ma[31:23], 23'($urandom)} : 32'($urandom);
            mb = 8'($urandom);
            db = ($urandom_range(0, 9) < 8) ? mb : 8'($urandom);
            r = $urandom_range(0, 99);
            step(r < 2, $urandom_range(0, 1) == 1, key($urandom_range(0, 23)),
                 $urandom_range(0, 2) != 0, key($urandom_range(0, 23)), 30'($urandom),
                 ma, da, mb, db, "R2");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule